// File: doc/BRIEF.md
# Region-Gated Automatic Gamma Selector

This block picks a 5-bit dynamic-range (gamma) code for an image sensor once per frame. While a frame streams past, it gathers two statistics. The first counts pixels at the full-scale digital value. The second counts pixels at or above a top-bin threshold. At the frame-end strobe it compares each count against a power-of-two limit and steps the code up or down. The step is limited by a maximum code and by a frame-skip rate.

A rectangular window can restrict the statistics to the pixels inside it or to the pixels outside it. It can also be switched off so the whole frame counts. The window corners sit on a coarse grid: multiples of 8 for columns and multiples of 4 for rows. A separate overlay flag marks pixels that lie on the window outline. This lets the window be drawn on the video.

A manual override replaces the automatic code at the output in the same cycle.

Top module: `roi_gamma_ctrl`

## Requirements
- R1: Both statistics restart from zero at every frame end. Pixels from one frame never contribute to the decision of a later frame.
- R2: A statistic counts as "over" for a frame when its count of qualifying pixels reaches 2^N. N is `satBits` for the full-scale count and `topBits` for the top-bin count. A full-scale pixel has `pixData` all ones. A top-bin pixel has `pixData >= topThresh`, so a full-scale pixel is also a top-bin pixel.
- R3: On an update frame where the full-scale count is over, the automatic code rises by one. This wins over a decrease.
- R4: On an update frame where the full-scale count is not over and the top-bin count is not over, the code falls by one. It does not go below 0. Otherwise the code holds.
- R5: After any update, the automatic code is at most `maxGamma`. A code above a lowered limit is pulled down to the limit.
- R6: Updates happen on every `skipFrames`-th frame end; a value of 0 acts as 1. The code is unchanged on the frame ends in between.
- R7: When `manualEn` is 1, `gammaCode` equals `manualGamma` in the same cycle. When it is 0, `gammaCode` shows the automatic code.
- R8: With `roiEn`=1, the window covers columns `{roiColOn,3'b000}` to `{roiColOff,3'b000}` and rows `{roiRowOn,2'b00}` to `{roiRowOff,2'b00}`, both ends inclusive. If `roiInside`=1, only pixels inside the window count. If `roiInside`=0, only pixels outside it count.
- R9: With `roiEn`=0, every valid pixel counts, whatever its position.
- R10: `boxFlag` is 1 exactly when `showBox` and `pixValid` are 1 and the pixel lies inside the window on its first or last row or column.
- R11: After reset the automatic code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| pixValid | input | 1 | Pixel present this cycle |
| pixRow | input | 10 | Row of the pixel |
| pixCol | input | 11 | Column of the pixel |
| pixData | input | 8 | Pixel value |
| frameEnd | input | 1 | One-cycle end-of-frame strobe |
| topThresh | input | 8 | Lowest value in the top bin |
| satBits | input | 4 | Log2 of the full-scale count limit |
| topBits | input | 4 | Log2 of the top-bin count limit |
| maxGamma | input | 5 | Highest automatic code |
| skipFrames | input | 4 | Frames between updates |
| manualEn | input | 1 | Select manual code |
| manualGamma | input | 5 | Manual code |
| roiEn | input | 1 | Window gates the statistics |
| roiInside | input | 1 | 1 counts inside, 0 counts outside |
| showBox | input | 1 | Enable outline overlay |
| roiColOn | input | 8 | Left column / 8 |
| roiColOff | input | 8 | Right column / 8 |
| roiRowOn | input | 8 | Top row / 4 |
| roiRowOff | input | 8 | Bottom row / 4 |
| gammaCode | output | 5 | Selected gamma code |
| boxFlag | output | 1 | Pixel lies on the window outline |

## Verification
A stuck or uncleared statistic shows up at the first update after the frame in which it matters. The code then takes the wrong step two clocks after that frame's end strobe. An off-by-one in the power-of-two limit or in the window edges only changes the step when the count sits exactly on the limit or the pixel sits exactly on a corner, so the bench places stimulus on those values. A wrong skip phase shows as a code change on a frame end that should hold.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int CODE_W = 5;

  typedef struct packed {
    logic frameDone;
    logic satOver;
    logic topOver;
  } stat_strobe_t;
endpackage

// File: rtl/roi_window.sv
module roi_window #(
  parameter int BOUND_W   = 8,
  parameter int COL_SHIFT = 3,
  parameter int ROW_SHIFT = 2,
  localparam int COL_W = BOUND_W + COL_SHIFT,
  localparam int ROW_W = BOUND_W + ROW_SHIFT
) (
  input  logic [ROW_W-1:0]   row,
  input  logic [COL_W-1:0]   col,
  input  logic [BOUND_W-1:0] colOn,
  input  logic [BOUND_W-1:0] colOff,
  input  logic [BOUND_W-1:0] rowOn,
  input  logic [BOUND_W-1:0] rowOff,
  output logic               inRect,
  output logic               onEdge
);
  logic [COL_W-1:0] colLo, colHi;
  logic [ROW_W-1:0] rowLo, rowHi;

  assign colLo = {colOn,  {COL_SHIFT{1'b0}}};
  assign colHi = {colOff, {COL_SHIFT{1'b0}}};
  assign rowLo = {rowOn,  {ROW_SHIFT{1'b0}}};
  assign rowHi = {rowOff, {ROW_SHIFT{1'b0}}};

  assign inRect = (col >= colLo) && (col <= colHi) && (row >= rowLo) && (row <= rowHi);
  assign onEdge = inRect && ((col == colLo) || (col == colHi) || (row == rowLo) || (row == rowHi));
endmodule

// File: rtl/stat_datapath.sv
module stat_datapath
  import gamma_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int CNT_W = 16,
  localparam int BITS_W = $clog2(CNT_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic              qualify,
  input  logic [PIX_W-1:0]  pixData,
  input  logic [PIX_W-1:0]  topThresh,
  input  logic              frameEnd,
  input  logic [BITS_W-1:0] satBits,
  input  logic [BITS_W-1:0] topBits,
  output stat_strobe_t      strobe
);
  logic [CNT_W-1:0] satCnt, topCnt;
  logic [CNT_W:0]   satInc, topInc;
  logic             satOver, topOver, satHit, topHit, satOverNext, topOverNext;

  assign satHit = pixValid && qualify && (pixData == {PIX_W{1'b1}});
  assign topHit = pixValid && qualify && (pixData >= topThresh);
  assign satInc = {1'b0, satCnt} + 1'b1;
  assign topInc = {1'b0, topCnt} + 1'b1;
  assign satOverNext = satOver || (satHit && ((satInc >> satBits) != '0));
  assign topOverNext = topOver || (topHit && ((topInc >> topBits) != '0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      satCnt  <= '0;
      topCnt  <= '0;
      satOver <= 1'b0;
      topOver <= 1'b0;
      strobe  <= '0;
    end else if (frameEnd) begin
      strobe  <= '{frameDone: 1'b1, satOver: satOverNext, topOver: topOverNext};
      satCnt  <= '0;
      topCnt  <= '0;
      satOver <= 1'b0;
      topOver <= 1'b0;
    end else begin
      strobe  <= '0;
      satOver <= satOverNext;
      topOver <= topOverNext;
      if (satHit && !satOver) satCnt <= satInc[CNT_W-1:0];
      if (topHit && !topOver) topCnt <= topInc[CNT_W-1:0];
    end
  end

  // R1: a frame end leaves both statistics empty
  p_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameEnd) |-> (satCnt == '0 && topCnt == '0 && !satOver && !topOver));
  // R2: an over flag stays set until the frame ends
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (satOver && !frameEnd) |=> satOver);
endmodule

// File: rtl/gamma_control.sv
module gamma_control
  import gamma_pkg::*;
#(
  parameter int SKIP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  stat_strobe_t      strobe,
  input  logic [CODE_W-1:0] maxGamma,
  input  logic [SKIP_W-1:0] skipFrames,
  output logic [CODE_W-1:0] autoCode
);
  logic [SKIP_W-1:0] skipCnt, effSkip;
  logic [SKIP_W:0]   skipNext;
  logic              updEn;
  logic [CODE_W:0]   stepped;
  logic [CODE_W-1:0] nextCode;

  assign effSkip  = (skipFrames == '0) ? SKIP_W'(1) : skipFrames;
  assign skipNext = {1'b0, skipCnt} + 1'b1;
  assign updEn    = strobe.frameDone && (skipNext >= {1'b0, effSkip});

  always_comb begin
    if (strobe.satOver)                         stepped = {1'b0, autoCode} + 1'b1;
    else if (!strobe.topOver && autoCode != '0) stepped = {1'b0, autoCode} - 1'b1;
    else                                        stepped = {1'b0, autoCode};
    nextCode = (stepped > {1'b0, maxGamma}) ? maxGamma : stepped[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skipCnt  <= '0;
      autoCode <= '0;
    end else if (strobe.frameDone) begin
      if (updEn) begin
        skipCnt  <= '0;
        autoCode <= nextCode;
      end else begin
        skipCnt <= skipNext[SKIP_W-1:0];
      end
    end
  end

  // R5: an update never leaves the code above the limit
  p_code_max_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(updEn) |-> (autoCode <= $past(maxGamma)));
  // R6: between updates the code holds
  p_skip_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(updEn) |-> $stable(autoCode));
  // R3: an over full-scale count with headroom raises the code by exactly one
  p_step_up_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(updEn && strobe.satOver && (autoCode < maxGamma)) |-> (autoCode == CODE_W'($past(autoCode) + 1'b1)));
endmodule

// File: rtl/roi_gamma_ctrl.sv
module roi_gamma_ctrl
  import gamma_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int CNT_W     = 16,
  parameter int SKIP_W    = 4,
  parameter int BOUND_W   = 8,
  parameter int COL_SHIFT = 3,
  parameter int ROW_SHIFT = 2,
  localparam int BITS_W = $clog2(CNT_W),
  localparam int COL_W  = BOUND_W + COL_SHIFT,
  localparam int ROW_W  = BOUND_W + ROW_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pixValid,
  input  logic [ROW_W-1:0]   pixRow,
  input  logic [COL_W-1:0]   pixCol,
  input  logic [PIX_W-1:0]   pixData,
  input  logic               frameEnd,
  input  logic [PIX_W-1:0]   topThresh,
  input  logic [BITS_W-1:0]  satBits,
  input  logic [BITS_W-1:0]  topBits,
  input  logic [CODE_W-1:0]  maxGamma,
  input  logic [SKIP_W-1:0]  skipFrames,
  input  logic               manualEn,
  input  logic [CODE_W-1:0]  manualGamma,
  input  logic               roiEn,
  input  logic               roiInside,
  input  logic               showBox,
  input  logic [BOUND_W-1:0] roiColOn,
  input  logic [BOUND_W-1:0] roiColOff,
  input  logic [BOUND_W-1:0] roiRowOn,
  input  logic [BOUND_W-1:0] roiRowOff,
  output logic [CODE_W-1:0]  gammaCode,
  output logic               boxFlag
);
  logic         inRect, onEdge, qualify;
  stat_strobe_t strobe;
  logic [CODE_W-1:0] autoCode;

  roi_window #(.BOUND_W(BOUND_W), .COL_SHIFT(COL_SHIFT), .ROW_SHIFT(ROW_SHIFT)) uWin (
    .row(pixRow), .col(pixCol), .colOn(roiColOn), .colOff(roiColOff),
    .rowOn(roiRowOn), .rowOff(roiRowOff), .inRect(inRect), .onEdge(onEdge));

  assign qualify = !roiEn || (inRect == roiInside);
  assign boxFlag = showBox && pixValid && onEdge;

  stat_datapath #(.PIX_W(PIX_W), .CNT_W(CNT_W)) uStat (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .qualify(qualify),
    .pixData(pixData), .topThresh(topThresh), .frameEnd(frameEnd),
    .satBits(satBits), .topBits(topBits), .strobe(strobe));

  gamma_control #(.SKIP_W(SKIP_W)) uCtl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .maxGamma(maxGamma),
    .skipFrames(skipFrames), .autoCode(autoCode));

  assign gammaCode = manualEn ? manualGamma : autoCode;

  // R10: the overlay is only ever raised on a valid pixel inside the window
  p_box_inside_r10: assert property (@(posedge clk) disable iff (!rstN)
    boxFlag |-> (pixValid && inRect));
endmodule

// File: tb/tb_roi_gamma_ctrl.sv
module tb_roi_gamma_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 9;
  // {full-scale pixels, extra top-bin pixels, expected code}
  localparam int VEC [N_VEC][3] = '{
    '{4, 0, 1}, '{3, 10, 1}, '{0, 7, 0}, '{0, 0, 0}, '{5, 0, 1},
    '{8, 0, 2}, '{4, 0, 3}, '{0, 8, 3}, '{0, 7, 2}};

  logic clk = 0, rstN = 0;
  logic pixValid = 0, frameEnd = 0;
  logic [9:0] pixRow = 0;
  logic [10:0] pixCol = 0;
  logic [7:0] pixData = 0, topThresh = 8'd200;
  logic [3:0] satBits = 4'd2, topBits = 4'd3, skipFrames = 4'd1;
  logic [4:0] maxGamma = 5'd31, manualGamma = 0;
  logic manualEn = 0, roiEn = 0, roiInside = 1, showBox = 0;
  logic [7:0] roiColOn = 8'd1, roiColOff = 8'd2, roiRowOn = 8'd1, roiRowOff = 8'd2;
  logic [4:0] gammaCode;
  logic boxFlag;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  roi_gamma_ctrl dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sendPix(input int r, input int c, input int d);
    pixValid = 1; pixRow = 10'(r); pixCol = 11'(c); pixData = 8'(d);
    @(negedge clk);
    pixValid = 0;
  endtask

  task automatic endFrame();
    frameEnd = 1;
    @(negedge clk);
    frameEnd = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic plainFrame(input int nSat, input int nTop);
    for (int i = 0; i < nSat; i++) sendPix(0, i, 255);
    for (int i = 0; i < nTop; i++) sendPix(1, i, 220);
    sendPix(2, 0, 10);
    endFrame();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset code", gammaCode, 0);
    check("R10 reset overlay", boxFlag, 0);
    rstN = 1;
    @(negedge clk);

    // R2 R3 R4: table of frames, update every frame
    for (int v = 0; v < N_VEC; v++) begin
      plainFrame(VEC[v][0], VEC[v][1]);
      check($sformatf("R2/R3/R4 vector %0d", v), gammaCode, VEC[v][2]);
    end

    // R5: clamp at the limit, then a lowered limit pulls the code down
    maxGamma = 5'd3;
    plainFrame(4, 0); check("R5 reach limit", gammaCode, 3);
    plainFrame(4, 0); check("R5 hold at limit", gammaCode, 3);
    maxGamma = 5'd1;
    plainFrame(4, 0); check("R5 lowered limit", gammaCode, 1);
    maxGamma = 5'd31;

    // R7: manual override is immediate
    manualEn = 1; manualGamma = 5'd17; #1;
    check("R7 manual value", gammaCode, 17);
    manualEn = 0; #1;
    check("R7 back to auto", gammaCode, 1);
    @(negedge clk);

    // R6: update every second frame
    skipFrames = 4'd2;
    plainFrame(4, 0); check("R6 skipped frame", gammaCode, 1);
    plainFrame(4, 0); check("R6 update frame", gammaCode, 2);
    skipFrames = 4'd1;

    // R1: two frames of 3 full-scale pixels each never reach 4
    topBits = 4'd0;
    plainFrame(3, 0); check("R1 first frame", gammaCode, 2);
    plainFrame(3, 0); check("R1 no carry-over", gammaCode, 2);

    // R8: window cols 8..16, rows 4..8, limit of one pixel
    satBits = 4'd0; roiEn = 1; roiInside = 1;
    sendPix(8, 16, 255); endFrame(); check("R8 inclusive corner", gammaCode, 3);
    sendPix(8, 17, 255); endFrame(); check("R8 outside ignored", gammaCode, 2);
    roiInside = 0;
    sendPix(3, 10, 255); endFrame(); check("R8 outside polarity", gammaCode, 3);
    sendPix(6, 12, 255); endFrame(); check("R8 inside ignored", gammaCode, 2);

    // R9: window off counts everywhere
    roiEn = 0;
    sendPix(6, 12, 255); endFrame(); check("R9 whole frame", gammaCode, 3);

    // R10: outline overlay
    showBox = 1;
    pixValid = 1; pixRow = 10'd4; pixCol = 11'd12; #1; check("R10 top edge", boxFlag, 1);
    pixRow = 10'd6; #1; check("R10 interior", boxFlag, 0);
    pixRow = 10'd8; pixCol = 11'd16; #1; check("R10 far corner", boxFlag, 1);
    pixRow = 10'd3; pixCol = 11'd12; #1; check("R10 above window", boxFlag, 0);
    pixRow = 10'd4; pixValid = 0; #1; check("R10 no pixel", boxFlag, 0);
    showBox = 0; pixValid = 1; #1; check("R10 overlay off", boxFlag, 0);
    pixValid = 0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule